// File: doc/BRIEF.md
# Key-protected watchdog timer

A watchdog timer that runs on a slow clock of about 32 kHz and is controlled through a small 16-bit register port. A prescaler divides the slow clock into 10 ms ticks. A 15-bit down-counter is reloaded from a programmable timeout and decrements once per tick while the watchdog is active. When one tick remains, an early-warning event is raised, and it can drive an interrupt line. When the count runs out, the block emits a one-cycle reset request. It then records a coded timed-out status, and that status is kept through the system reset it causes.

Every control action is protected by a 16-bit key. Feeding, resuming and clearing status each take their own key. Disabling takes an ordered pair of key writes to two registers, and any other write between them cancels the pair. A debug-mode input freezes the watchdog unless software sets an override bit. The count readback carries a flag that tells software the value is still settling, so software rereads until the flag is clear.

Registers are addressed by byte offset (word index = `addr_i[5:2]`). Reads are combinational on `addr_i`. A write takes effect at the clock edge where `we_i` is high.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset the watchdog is disabled (offset 0x0C reads 0xDABE), the timeout at 0x04 reads 6000, status 0x10 reads 0x0000, the interrupt enable 0x24 and the event bit 0x20 read 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0xFEED to offset 0x00 reloads the down-counter from the timeout value. Any other value written there leaves the counter running undisturbed.
- R3: Offset 0x04 holds a 15-bit timeout in ticks. One tick is PRESCALE clock cycles, and an active counter drops by exactly one per tick.
- R4: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C disables the watchdog. Offset 0x0C then reads 0xDABE (0x0000 while enabled), and a disabled counter does not move.
- R5: A 0xCAFE write to 0x0C without a directly preceding 0x2BAD write has no effect. A write to any other register, or any other value at 0x0C, between the two steps cancels the sequence.
- R6: Writing 0xACED to 0x1C enables the watchdog and reloads the counter. Other values there are ignored.
- R7: The event bit sets on the tick that brings the counter to 1. Exactly PRESCALE cycles later `rst_req_o` pulses for one cycle, and the counter is reloaded from the timeout.
- R8: After an expiry, 0x10 reads 0xCFE8 and stays so until 0xE8B4 is written there, which returns it to 0x0000. Other values are ignored.
- R9: Offset 0x14 bit 15 is 1 in the cycle after the counter changes, and bits 14:0 then carry the previous count. Otherwise bit 15 is 0 and bits 14:0 carry the current count.
- R10: `irq_o` is the event bit gated by bit 0 of 0x24. Bit 0 of 0x28 forces the event set, and a set that meets an acknowledge in the same cycle wins.
- R11: Writing bit 0 = 1 to 0x20 clears the event bit 3 cycles after the write edge. It still reads 1 for the two cycles after the write.
- R12: While `dbg_i` is high the counter is frozen unless bit 0 of 0x18 is set. Bit 1 of 0x18 reads `dbg_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow clock (about 32 kHz) |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| dbg_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The event register can receive a set and a delayed acknowledge in the same cycle. The bench provokes this by holding the force bit while it writes an acknowledge, so the clear lands in a cycle that also asserts a set. It judges the result by reading the event bit after the acknowledge delay has fully elapsed: the bit must still read 1. It then drops the force bit, acknowledges again and expects the bit to clear. The warning-to-reset spacing is judged by counting cycles from the rise of `irq_o` to the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [15:0] KEY_FEED   = 16'hFEED;
  localparam logic [15:0] KEY_DIS_A  = 16'h2BAD;
  localparam logic [15:0] KEY_DIS_B  = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME = 16'hACED;
  localparam logic [15:0] KEY_CLR    = 16'hE8B4;
  localparam logic [15:0] CODE_OFF   = 16'hDABE;
  localparam logic [15:0] CODE_ON    = 16'h0000;
  localparam logic [15:0] STAT_HIT   = 16'hCFE8;
  localparam logic [15:0] STAT_OK    = 16'h0000;

  typedef enum logic [3:0] {
    REG_FEED   = 4'd0,
    REG_TMO    = 4'd1,
    REG_DIS_A  = 4'd2,
    REG_DIS_B  = 4'd3,
    REG_STAT   = 4'd4,
    REG_CNT    = 4'd5,
    REG_DBG    = 4'd6,
    REG_RESUME = 4'd7,
    REG_EVT    = 4'd8,
    REG_MASK   = 4'd9,
    REG_FORCE  = 4'd10
  } reg_idx_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 328
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/wdt_enable_ctl.sv
module wdt_enable_ctl
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  idx_i,
  input  logic [15:0] data_i,
  output logic        en_o
);
  logic armed_q, en_q;
  logic hit_a, hit_b, hit_resume;

  assign hit_a      = (idx_i == REG_DIS_A)  && (data_i == KEY_DIS_A);
  assign hit_b      = (idx_i == REG_DIS_B)  && (data_i == KEY_DIS_B);
  assign hit_resume = (idx_i == REG_RESUME) && (data_i == KEY_RESUME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (wr_i) begin
      // any write re-evaluates the arm: only the first key leaves it set
      armed_q <= hit_a;
      if (armed_q && hit_b) en_q <= 1'b0;
      else if (hit_resume)  en_q <= 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          CNT_W   = 15,
  parameter int unsigned RST_VAL = 6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   rd_o,
  output logic             warn_o,
  output logic             expire_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(RST_VAL);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, shadow_q;
  logic             rst_q, step, busy;

  assign step     = tick_i && active_i && !reload_i;
  assign warn_o   = step && (cnt_q == TWO);
  assign expire_o = step && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= INIT;
      shadow_q <= INIT;
      rst_q    <= 1'b0;
    end else begin
      if (reload_i || expire_o) cnt_q <= tmo_i;
      else if (step)            cnt_q <= cnt_q - 1'b1;
      shadow_q <= cnt_q;
      rst_q    <= expire_o;
    end
  end

  assign busy      = (cnt_q != shadow_q);
  assign rd_o      = busy ? {1'b1, shadow_q} : {1'b0, cnt_q};
  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq #(
  parameter int ACK_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic force_i,
  input  logic mask_i,
  output logic evt_o,
  output logic irq_o
);
  localparam int D = (ACK_DLY < 1) ? 1 : ACK_DLY;

  logic [D-1:0] pipe_q;
  logic         evt_q, clr;

  generate
    if (D == 1) begin : g_short
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= ack_i;
      end
    end else begin : g_long
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[D-2:0], ack_i};
      end
    end
  endgenerate

  assign clr = pipe_q[D-1];

  // a set arriving with a completing acknowledge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= (evt_q && !clr) || set_i || force_i;
  end

  assign evt_o = evt_q;
  assign irq_o = evt_q && mask_i;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int          PRESCALE    = 328,
  parameter int unsigned TIMEOUT_RST = 6000,
  parameter int          ACK_DLY     = 3,
  parameter int          ADDR_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              dbg_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = 15;

  logic [3:0]       idx;
  logic [CNT_W-1:0] tmo_q, cnt;
  logic [CNT_W:0]   cnt_rd;
  logic             status_q, mask_q, force_q, jtag_q;
  logic             tick, en, active, feed, resume, reload, ack;
  logic             warn, expire, evt;

  assign idx    = 4'(addr_i[ADDR_W-1:2]);
  assign feed   = we_i && (idx == REG_FEED)   && (wdata_i == KEY_FEED);
  assign resume = we_i && (idx == REG_RESUME) && (wdata_i == KEY_RESUME);
  assign reload = feed || resume;
  assign ack    = we_i && (idx == REG_EVT) && wdata_i[0];
  assign active = en && (!dbg_i || jtag_q);

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  wdt_enable_ctl u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(we_i),
    .idx_i(idx), .data_i(wdata_i), .en_o(en)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_VAL(TIMEOUT_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .active_i(active),
    .reload_i(reload), .tmo_i(tmo_q), .cnt_o(cnt), .rd_o(cnt_rd),
    .warn_o(warn), .expire_o(expire), .rst_req_o(rst_req_o)
  );

  wdt_irq #(.ACK_DLY(ACK_DLY)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(warn), .ack_i(ack),
    .force_i(force_q), .mask_i(mask_q), .evt_o(evt), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q    <= CNT_W'(TIMEOUT_RST);
      status_q <= 1'b0;
      mask_q   <= 1'b0;
      force_q  <= 1'b0;
      jtag_q   <= 1'b0;
    end else begin
      if (expire) status_q <= 1'b1;
      else if (we_i && idx == REG_STAT && wdata_i == KEY_CLR) status_q <= 1'b0;
      if (we_i) begin
        case (idx)
          REG_TMO:   tmo_q   <= wdata_i[CNT_W-1:0];
          REG_MASK:  mask_q  <= wdata_i[0];
          REG_FORCE: force_q <= wdata_i[0];
          REG_DBG:   jtag_q  <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      REG_TMO:   rdata_o = {1'b0, tmo_q};
      REG_DIS_B: rdata_o = en ? CODE_ON : CODE_OFF;
      REG_STAT:  rdata_o = status_q ? STAT_HIT : STAT_OK;
      REG_CNT:   rdata_o = cnt_rd;
      REG_DBG:   rdata_o = {14'd0, dbg_i, jtag_q};
      REG_EVT:   rdata_o = {15'd0, evt};
      REG_MASK:  rdata_o = {15'd0, mask_q};
      REG_FORCE: rdata_o = {15'd0, force_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req,
  input logic             status,
  input logic             active,
  input logic             reload,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tmo
);
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> !rst_req);

  assert_rst_needs_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |-> $past(active));

  assert_status_on_expiry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |-> status);

  assert_status_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status) |-> rst_req);

  assert_reload_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (cnt == $past(tmo)));

  assert_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !reload) |=> $stable(cnt));
endmodule

bind wdt_top wdt_checker #(.CNT_W(15)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_req(rst_req_o), .status(status_q),
  .active(active), .reload(reload), .cnt(cnt), .tmo(tmo_q)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int CLK_T = 10;
  localparam int PRE   = 4;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, dbg = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq, rst_req;
  int          total = 0, bad = 0;

  always #(CLK_T/2) clk = ~clk;

  wdt_top #(.PRESCALE(PRE), .TIMEOUT_RST(6000), .ACK_DLY(3), .ADDR_W(6)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dbg_i(dbg), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disable_wd();
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(6'h0C, d); chk("R1 disabled code", d, 16'hDABE);
    rd(6'h04, d); chk("R1 timeout", d, 16'd6000);
    rd(6'h10, d); chk("R1 status", d, 16'h0000);
    rd(6'h24, d); chk("R1 mask", d, 16'h0000);
    rd(6'h20, d); chk("R1 event", d, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rst_req", {15'd0, rst_req}, 16'd0);
  endtask

  task automatic t_disable();
    logic [15:0] d, c1, c2;
    wr(6'h04, 16'd40);
    wr(6'h1C, 16'h1234); rd(6'h0C, d); chk("R6 bad resume key", d, 16'hDABE);
    wr(6'h1C, 16'hACED); rd(6'h0C, d); chk("R6 resume", d, 16'h0000);
    wr(6'h0C, 16'hCAFE); rd(6'h0C, d); chk("R5 unarmed second key", d, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h04, 16'd40); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, d); chk("R5 other register between", d, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'h1111); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, d); chk("R5 wrong value between", d, 16'h0000);
    disable_wd();
    rd(6'h0C, d); chk("R4 disabled", d, 16'hDABE);
    idle(2); rd(6'h14, c1);
    idle(3*PRE); rd(6'h14, c2);
    chk("R4 frozen count", c2, c1);
  endtask

  task automatic t_feed();
    logic [15:0] d;
    wr(6'h04, 16'd50);
    wr(6'h00, 16'hFEED);
    rd(6'h14, d); chk("R9 settling flag", {15'd0, d[15]}, 16'd1);
    idle(1);
    rd(6'h14, d); chk("R9 settled value", d, 16'd50);
    wr(6'h1C, 16'hACED);
    idle(5*PRE);
    rd(6'h14, d);
    chk("R3 five ticks elapsed", {15'd0, (d[14:0] >= 15'd44) && (d[14:0] <= 15'd46)}, 16'd1);
    wr(6'h00, 16'h1234);
    rd(6'h14, d); chk("R2 bad feed key ignored", {15'd0, d[14:0] < 15'd48}, 16'd1);
    wr(6'h00, 16'hFEED);
    idle(1);
    rd(6'h14, d); chk("R2 feed reload", {1'b0, d[14:0]}, 16'd50);
  endtask

  task automatic t_expiry();
    logic [15:0] d;
    int n;
    wr(6'h24, 16'd1);
    wr(6'h04, 16'd3);
    wr(6'h00, 16'hFEED);
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk("R7 warning raised", {15'd0, irq}, 16'd1);
    rd(6'h20, d); chk("R7 event bit", d, 16'd1);
    chk("R7 no reset at warning", {15'd0, rst_req}, 16'd0);
    n = 0;
    while (!rst_req && n < 100) begin @(negedge clk); n++; end
    chk("R7 warning to reset spacing", 16'(n), 16'(PRE));
    @(negedge clk);
    chk("R7 reset one cycle", {15'd0, rst_req}, 16'd0);
    rd(6'h14, d); chk("R7 reload after expiry", d, 16'd3);
    rd(6'h10, d); chk("R8 timed out code", d, 16'hCFE8);
    disable_wd();
    wr(6'h10, 16'h1111); rd(6'h10, d); chk("R8 sticky on bad key", d, 16'hCFE8);
    wr(6'h10, 16'hE8B4); rd(6'h10, d); chk("R8 cleared", d, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    rd(6'h20, d); chk("R11 event pending", d, 16'd1);
    wr(6'h20, 16'd1);
    idle(2); rd(6'h20, d); chk("R11 still set before delay", d, 16'd1);
    idle(1); rd(6'h20, d); chk("R11 cleared after delay", d, 16'd0);
    wr(6'h24, 16'd0);
    wr(6'h28, 16'd1);
    idle(1);
    rd(6'h20, d); chk("R10 forced event", d, 16'd1);
    chk("R10 masked irq", {15'd0, irq}, 16'd0);
    wr(6'h24, 16'd1);
    chk("R10 unmasked irq", {15'd0, irq}, 16'd1);
    wr(6'h20, 16'd1);
    idle(5);
    rd(6'h20, d); chk("R10 set wins over ack", d, 16'd1);
    wr(6'h28, 16'd0);
    wr(6'h20, 16'd1);
    idle(4);
    rd(6'h20, d); chk("R10 ack after force off", d, 16'd0);
    chk("R10 irq low", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_debug();
    logic [15:0] d, c1, c2, c3;
    dbg = 1'b1;
    rd(6'h18, d); chk("R12 debug indication", d, 16'd2);
    wr(6'h04, 16'd100);
    wr(6'h1C, 16'hACED);
    idle(3*PRE); rd(6'h14, c1);
    idle(3*PRE); rd(6'h14, c2);
    chk("R12 frozen in debug", c2, c1);
    wr(6'h18, 16'd1);
    rd(6'h18, d); chk("R12 override readback", d, 16'd3);
    idle(3*PRE + 1); rd(6'h14, c3);
    chk("R12 runs with override", {15'd0, c3[14:0] < c2[14:0]}, 16'd1);
    dbg = 1'b0;
    disable_wd();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_disable();
    t_feed();
    t_expiry();
    t_irq();
    t_debug();
    finish_run();
  end
endmodule